// File: doc/BRIEF.md
# SMBus host controller register unit

This block is the software-facing side of a host SMBus controller. A byte-wide register port lets software load a command code, a target address with its direction bit, and two data bytes. Software then writes the control register with the start bit set. The unit checks the selected protocol. If the protocol is usable, it sends a single request to a separate bus engine, which runs the transfer on the wire and later returns a done or error response together with any bytes it read.

The status register reports the progress and the result of a transfer. Software clears its bits by writing ones to them, except the busy bit, which only the hardware can change. A kill bit in the control register abandons a transfer that is in flight. A level interrupt follows the status bits when it is enabled. Register reads are combinational from the current register state and have no side effects.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low and `req_valid` is low.
- R2: Offsets 0x03 command, 0x04 address, 0x05 data-low, 0x06 data-high and 0x07 block byte read back what was written. Offset 0x0D keeps only bits 1:0. Every other offset reads 0x00.
- R3: In the control register (0x02), bit 0 is interrupt enable, bit 1 is kill, bits 4:2 are the protocol code and bit 6 is start. Start is never stored, and a control read returns only bits 4:0.
- R4: The status register (0x00) has busy at bit 0, done at bit 1, device error at bit 2 and failed at bit 4. A status write clears each of bits 7:1 that is written as one. Busy cannot be cleared by a status write.
- R5: A start with a usable protocol sets busy and raises `req_valid` for exactly one cycle, in the cycle after the write. The request carries the protocol code, the direction (address bit 0, 1 = read), the target (address bits 7:1), the command byte and {data-high, data-low}.
- R6: Protocol codes 5 and 7, and code 6 with a write direction, issue no request and set device error instead. The usable codes are 0 quick, 1 byte, 2 byte-data, 3 word-data, 4 process call and 6 I2C block read.
- R7: A start while device error is set issues no request, leaves busy clear and keeps device error set.
- R8: A done response clears busy and sets done. Reads with code 1, 2 or 6 load the low response byte into data-low. Word reads (code 3) and process calls (code 4) load data-high with the high response byte and data-low with the low byte. Quick transfers and writes leave the data registers alone.
- R9: An error response clears busy, sets device error and leaves the data registers unchanged.
- R10: Writing control with kill set clears busy and sets failed, whether or not start is also set. No request is issued, and a response that arrives later is ignored.
- R11: `irq` is high exactly when interrupt enable is set and any of status bits 7:1 is set.
- R12: A start written while busy is set is ignored: no second request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| req_valid | output | 1 | One-cycle request to the bus engine |
| req_proto | output | 3 | Protocol code of the request |
| req_read | output | 1 | Direction of the request, 1 = read |
| req_target | output | 7 | Target address |
| req_cmd | output | 8 | Command byte |
| req_wdata | output | 16 | {data-high, data-low} to send |
| rsp_valid | input | 1 | Response from the engine |
| rsp_err | input | 1 | Response reports a bus failure or NAK |
| rsp_rdata | input | 16 | Bytes returned by the engine |

## Verification
The bench runs random transfers across all eight protocol codes and both directions, with random engine latency and random error responses. It also leaves device error uncleared on purpose, so that later starts meet a pending error. A design that forwarded requests despite that error, or that accepted code 6 writes, would show a stray `req_valid`. Directed cases write all ones to the status register while a transfer is in flight: a design that let software clear busy would show busy low. Further directed cases kill a transfer and then deliver its response late: a design that still accepted it would change data-low and set done. Starts repeated while busy would show as a second request pulse.

// File: rtl/smbh_pkg.sv
`timescale 1ns/1ps
package smbh_pkg;
    localparam int DW    = 8;
    localparam int NREG  = 8;

    localparam int IDX_STATUS = 0;
    localparam int IDX_CTRL   = 1;
    localparam int IDX_CMD    = 2;
    localparam int IDX_ADDR   = 3;
    localparam int IDX_D0     = 4;
    localparam int IDX_D1     = 5;
    localparam int IDX_BLK    = 6;
    localparam int IDX_AUX    = 7;

    localparam int ST_BUSY   = 0;
    localparam int ST_DONE   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_FAILED = 4;

    localparam int CT_IEN   = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_START = 6;

    typedef enum logic [2:0] {
        PR_QUICK     = 3'd0,
        PR_BYTE      = 3'd1,
        PR_BYTE_DATA = 3'd2,
        PR_WORD      = 3'd3,
        PR_PCALL     = 3'd4,
        PR_BLOCK     = 3'd5,
        PR_I2C_RD    = 3'd6,
        PR_RSVD      = 3'd7
    } proto_e;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_BYTE = 2'd1,
        CAP_WORD = 2'd2
    } cap_e;

    typedef struct packed {
        logic [DW-1:0] sts;
        logic [DW-1:0] ctl;
        logic [DW-1:0] cmd;
        logic [DW-1:0] addr;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [DW-1:0] blk;
        logic [1:0]    aux;
        logic [2:0]    fl_proto;
        logic          fl_read;
        cap_e          fl_cap;
        logic          req;
    } regs_t;

    function automatic logic [DW-1:0] reg_ofs(input int idx);
        case (idx)
            IDX_STATUS: reg_ofs = 8'h00;
            IDX_CTRL:   reg_ofs = 8'h02;
            IDX_CMD:    reg_ofs = 8'h03;
            IDX_ADDR:   reg_ofs = 8'h04;
            IDX_D0:     reg_ofs = 8'h05;
            IDX_D1:     reg_ofs = 8'h06;
            IDX_BLK:    reg_ofs = 8'h07;
            default:    reg_ofs = 8'h0D;
        endcase
    endfunction
endpackage

// File: rtl/smbh_decode.sv
`timescale 1ns/1ps
module smbh_decode
    import smbh_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic [DW-1:0] addr,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = (addr == reg_ofs(i));
    end
endmodule

// File: rtl/smbh_proto_check.sv
`timescale 1ns/1ps
module smbh_proto_check
    import smbh_pkg::*;
(
    input  logic [2:0] proto,
    input  logic       rd,
    output logic       legal,
    output cap_e       cap
);
    always_comb begin
        legal = 1'b1;
        cap   = CAP_NONE;
        case (proto_e'(proto))
            PR_QUICK:     cap = CAP_NONE;
            PR_BYTE:      cap = rd ? CAP_BYTE : CAP_NONE;
            PR_BYTE_DATA: cap = rd ? CAP_BYTE : CAP_NONE;
            PR_WORD:      cap = rd ? CAP_WORD : CAP_NONE;
            PR_PCALL:     cap = CAP_WORD;
            PR_I2C_RD: begin
                legal = rd;
                cap   = rd ? CAP_BYTE : CAP_NONE;
            end
            default:      legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbh_readmux.sv
`timescale 1ns/1ps
module smbh_readmux
    import smbh_pkg::*;
(
    input  logic [NREG-1:0] hit,
    input  logic [DW-1:0]   sts,
    input  logic [4:0]      ctl_lo,
    input  logic [DW-1:0]   cmd,
    input  logic [DW-1:0]   addr,
    input  logic [DW-1:0]   d0,
    input  logic [DW-1:0]   d1,
    input  logic [DW-1:0]   blk,
    input  logic [1:0]      aux,
    output logic [DW-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        if (hit[IDX_STATUS]) rdata = sts;
        if (hit[IDX_CTRL])   rdata = {3'b000, ctl_lo};
        if (hit[IDX_CMD])    rdata = cmd;
        if (hit[IDX_ADDR])   rdata = addr;
        if (hit[IDX_D0])     rdata = d0;
        if (hit[IDX_D1])     rdata = d1;
        if (hit[IDX_BLK])    rdata = blk;
        if (hit[IDX_AUX])    rdata = {6'b000000, aux};
    end
endmodule

// File: rtl/smbus_host_regs.sv
`timescale 1ns/1ps
module smbus_host_regs
    import smbh_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          req_valid,
    output logic [2:0]    req_proto,
    output logic          req_read,
    output logic [6:0]    req_target,
    output logic [7:0]    req_cmd,
    output logic [15:0]   req_wdata,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    input  logic [15:0]   rsp_rdata
);
    regs_t           q, d;
    logic [NREG-1:0] hit;
    logic            legal;
    cap_e            cap;
    logic            kill_now, start_now;

    logic            wr_ctrl_w, wr_sts_w;
    logic            busy_w, deverr_w, failed_w, ien_w;

    smbh_decode #(.N(NREG)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    smbh_proto_check u_chk_proto (
        .proto (reg_wdata[4:2]),
        .rd    (q.addr[0]),
        .legal (legal),
        .cap   (cap)
    );

    smbh_readmux u_rmux (
        .hit    (hit),
        .sts    (q.sts),
        .ctl_lo (q.ctl[4:0]),
        .cmd    (q.cmd),
        .addr   (q.addr),
        .d0     (q.d0),
        .d1     (q.d1),
        .blk    (q.blk),
        .aux    (q.aux),
        .rdata  (reg_rdata)
    );

    assign wr_ctrl_w = reg_wr && hit[IDX_CTRL];
    assign wr_sts_w  = reg_wr && hit[IDX_STATUS];
    assign kill_now  = wr_ctrl_w && reg_wdata[CT_KILL];
    assign start_now = wr_ctrl_w && reg_wdata[CT_START];

    always_comb begin
        d     = q;
        d.req = 1'b0;

        // register writes
        if (reg_wr) begin
            if (hit[IDX_STATUS]) d.sts  = q.sts & ~(reg_wdata & 8'hFE);
            if (hit[IDX_CTRL])   d.ctl  = reg_wdata & ~(8'h01 << CT_START);
            if (hit[IDX_CMD])    d.cmd  = reg_wdata;
            if (hit[IDX_ADDR])   d.addr = reg_wdata;
            if (hit[IDX_D0])     d.d0   = reg_wdata;
            if (hit[IDX_D1])     d.d1   = reg_wdata;
            if (hit[IDX_BLK])    d.blk  = reg_wdata;
            if (hit[IDX_AUX])    d.aux  = reg_wdata[1:0];
        end

        // engine response (hardware events win over same-cycle writes)
        if (q.sts[ST_BUSY] && rsp_valid && !kill_now) begin
            d.sts[ST_BUSY] = 1'b0;
            if (rsp_err) begin
                d.sts[ST_DEVERR] = 1'b1;
            end else begin
                d.sts[ST_DONE] = 1'b1;
                case (q.fl_cap)
                    CAP_BYTE: d.d0 = rsp_rdata[7:0];
                    CAP_WORD: begin
                        d.d0 = rsp_rdata[7:0];
                        d.d1 = rsp_rdata[15:8];
                    end
                    default: ;
                endcase
            end
        end

        // start dispatch
        if (start_now && !kill_now && !q.sts[ST_BUSY] && !q.sts[ST_DEVERR]) begin
            if (!legal) begin
                d.sts[ST_DEVERR] = 1'b1;
            end else begin
                d.sts[ST_BUSY] = 1'b1;
                d.req          = 1'b1;
                d.fl_proto     = reg_wdata[4:2];
                d.fl_read      = q.addr[0];
                d.fl_cap       = cap;
            end
        end

        // abort
        if (kill_now) begin
            d.sts[ST_BUSY]   = 1'b0;
            d.sts[ST_FAILED] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq        = q.ctl[CT_IEN] && (q.sts[7:1] != 7'd0);
    assign req_valid  = q.req;
    assign req_proto  = q.fl_proto;
    assign req_read   = q.fl_read;
    assign req_target = q.addr[7:1];
    assign req_cmd    = q.cmd;
    assign req_wdata  = {q.d1, q.d0};

    assign busy_w   = q.sts[ST_BUSY];
    assign deverr_w = q.sts[ST_DEVERR];
    assign failed_w = q.sts[ST_FAILED];
    assign ien_w    = q.ctl[CT_IEN];
endmodule

// File: rtl/smbh_checker.sv
`timescale 1ns/1ps
module smbh_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_ctrl,
    input logic wr_sts,
    input logic kill_bit,
    input logic start_bit,
    input logic req_valid,
    input logic rsp_valid,
    input logic busy,
    input logic deverr,
    input logic failed,
    input logic ien,
    input logic irq
);
    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_sts && !rsp_valid |=> busy);

    assert_deverr_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && start_bit && deverr |=> !req_valid && deverr);

    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rsp_valid && !(wr_ctrl && kill_bit) |=> !busy);

    assert_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && kill_bit |=> failed && !busy && !req_valid);

    assert_irq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_ctrl && start_bit |=> !req_valid);
endmodule

bind smbus_host_regs smbh_checker u_smbh_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl_w),
    .wr_sts    (wr_sts_w),
    .kill_bit  (reg_wdata[1]),
    .start_bit (reg_wdata[6]),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .busy      (busy_w),
    .deverr    (deverr_w),
    .failed    (failed_w),
    .ien       (ien_w),
    .irq       (irq)
);

// File: tb/test_smbus_host_regs.sv
`timescale 1ns/1ps
module test_smbus_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq;
    logic        req_valid;
    logic [2:0]  req_proto;
    logic        req_read;
    logic [6:0]  req_target;
    logic [7:0]  req_cmd;
    logic [15:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_err = 1'b0;
    logic [15:0] rsp_rdata = 16'h0000;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_sts, m_ctl, m_cmd, m_addr, m_d0, m_d1;

    smbus_host_regs i_smbus_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .req_valid(req_valid), .req_proto(req_proto), .req_read(req_read),
        .req_target(req_target), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic respond(input logic err, input logic [15:0] data);
        rsp_valid = 1'b1; rsp_err = err; rsp_rdata = data;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        #1;
    endtask

    function automatic logic usable(input logic [2:0] pr, input logic dir);
        return !(pr == 3'd5 || pr == 3'd7 || (pr == 3'd6 && !dir));
    endfunction

    function automatic logic exp_irq(input logic [7:0] c, input logic [7:0] s);
        return c[0] && (s[7:1] != 7'd0);
    endfunction

    task automatic model_result(input logic [2:0] pr, input logic dir,
                                input logic err, input logic [15:0] rdat);
        m_sts[0] = 1'b0;
        if (err) m_sts[2] = 1'b1;
        else begin
            m_sts[1] = 1'b1;
            if (pr == 3'd4 || (dir && pr == 3'd3)) begin
                m_d0 = rdat[7:0]; m_d1 = rdat[15:8];
            end else if (dir && (pr == 3'd1 || pr == 3'd2 || pr == 3'd6)) begin
                m_d0 = rdat[7:0];
            end
        end
    endtask

    task automatic check_regs(input string tag);
        logic [7:0] v;
        rd(8'h00, v); chk({tag, " R4 status"}, {8'h00, v}, {8'h00, m_sts});
        rd(8'h05, v); chk({tag, " R8 data-low"}, {8'h00, v}, {8'h00, m_d0});
        rd(8'h06, v); chk({tag, " R8 data-high"}, {8'h00, v}, {8'h00, m_d1});
        rd(8'h02, v); chk({tag, " R3 ctrl"}, {8'h00, v}, {8'h00, m_ctl & 8'h1F});
        chk({tag, " R11 irq"}, {15'd0, irq}, {15'd0, exp_irq(m_ctl, m_sts)});
    endtask

    task automatic do_txn(input logic [2:0] pr, input logic dir, input logic ien,
                          input logic err, input logic [15:0] rdat, input int dly);
        logic [7:0] v, cval;
        logic go;
        m_addr = {7'($urandom), dir};
        m_cmd  = 8'($urandom);
        m_d0   = 8'($urandom);
        m_d1   = 8'($urandom);
        wr(8'h04, m_addr); wr(8'h03, m_cmd); wr(8'h05, m_d0); wr(8'h06, m_d1);
        cval  = {1'b0, 1'b1, 1'b0, pr, 1'b0, ien};
        m_ctl = cval & 8'hBF;
        go = 1'b0;
        if (m_sts[2]) go = 1'b0;
        else if (!usable(pr, dir)) m_sts[2] = 1'b1;
        else begin go = 1'b1; m_sts[0] = 1'b1; end
        wr(8'h02, cval);
        chk("R5/R6/R7 request issued", {15'd0, req_valid}, {15'd0, go});
        if (go) begin
            chk("R5 proto", {13'd0, req_proto}, {13'd0, pr});
            chk("R5 dir", {15'd0, req_read}, {15'd0, dir});
            chk("R5 target", {9'd0, req_target}, {9'd0, m_addr[7:1]});
            chk("R5 cmd", {8'd0, req_cmd}, {8'd0, m_cmd});
            chk("R5 wdata", req_wdata, {m_d1, m_d0});
            @(negedge clk); #1;
            chk("R5 single pulse", {15'd0, req_valid}, 16'd0);
            rd(8'h00, v);
            chk("R5 busy", {15'd0, v[0]}, 16'd1);
            repeat (dly) @(negedge clk);
            #1;
            respond(err, rdat);
            model_result(pr, dir, err, rdat);
        end
        check_regs("txn");
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_sts = 0; m_ctl = 0; m_cmd = 0; m_addr = 0; m_d0 = 0; m_d1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        for (int i = 0; i < 16; i++) begin
            rd(8'(i), v);
            chk("R1 reset register", {8'h00, v}, 16'h0000);
        end
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 req", {15'd0, req_valid}, 16'd0);

        // R2 map and unmapped offsets
        wr(8'h03, 8'hA5); wr(8'h04, 8'h3C); wr(8'h05, 8'h11); wr(8'h06, 8'h22);
        wr(8'h07, 8'h77); wr(8'h0D, 8'hFF); wr(8'h01, 8'hFF); wr(8'h20, 8'hFF);
        rd(8'h03, v); chk("R2 cmd", {8'h00, v}, 16'h00A5);
        rd(8'h04, v); chk("R2 addr", {8'h00, v}, 16'h003C);
        rd(8'h05, v); chk("R2 d0", {8'h00, v}, 16'h0011);
        rd(8'h06, v); chk("R2 d1", {8'h00, v}, 16'h0022);
        rd(8'h07, v); chk("R2 blk", {8'h00, v}, 16'h0077);
        rd(8'h0D, v); chk("R2 aux mask", {8'h00, v}, 16'h0003);
        rd(8'h01, v); chk("R2 unmapped 01", {8'h00, v}, 16'h0000);
        rd(8'h20, v); chk("R2 unmapped 20", {8'h00, v}, 16'h0000);
        m_cmd = 8'hA5; m_addr = 8'h3C; m_d0 = 8'h11; m_d1 = 8'h22;

        // R3 control read without start: bits 7:5 hidden, no request
        wr(8'h02, 8'hBD);
        chk("R3 no start no req", {15'd0, req_valid}, 16'd0);
        rd(8'h02, v); chk("R3 ctrl low bits", {8'h00, v}, 16'h001D);
        // R10 kill alone sets failed
        m_sts[4] = 1'b1; m_ctl = 8'hBD;
        chk("R11 irq on failed", {15'd0, irq}, 16'd0);
        wr(8'h02, 8'h02); m_ctl = 8'h02;
        rd(8'h00, v); chk("R10 failed set", {8'h00, v}, 16'h0010);
        wr(8'h02, 8'h01); m_ctl = 8'h01;
        chk("R11 irq high", {15'd0, irq}, 16'd1);
        wr(8'h00, 8'hFF); m_sts = 8'h00;
        chk("R11 irq low after clear", {15'd0, irq}, 16'd0);

        // R4/R12 busy not clearable, restart ignored
        m_addr = 8'h51; wr(8'h04, m_addr);
        wr(8'h02, 8'h4D); m_ctl = 8'h0D; m_sts[0] = 1'b1; // word read
        chk("R5 directed req", {15'd0, req_valid}, 16'd1);
        wr(8'h00, 8'hFF);
        rd(8'h00, v); chk("R4 busy survives write", {8'h00, v}, 16'h0001);
        wr(8'h02, 8'h4D);
        chk("R12 no second req", {15'd0, req_valid}, 16'd0);
        respond(1'b0, 16'hBEEF);
        model_result(3'd3, 1'b1, 1'b0, 16'hBEEF);
        check_regs("R8 word read");

        // R10 kill in flight, late response ignored
        wr(8'h00, 8'hFE); m_sts = 8'h00;
        wr(8'h02, 8'h49); m_ctl = 8'h09; m_sts[0] = 1'b1; // byte-data read
        chk("R10 setup req", {15'd0, req_valid}, 16'd1);
        wr(8'h02, 8'h03); m_ctl = 8'h03; m_sts = 8'h10;
        respond(1'b0, 16'h1234);
        check_regs("R10 late response");
        // kill together with start
        wr(8'h00, 8'hFE); m_sts = 8'h00;
        wr(8'h02, 8'h4A); m_ctl = 8'h0A; m_sts = 8'h10;
        chk("R10 kill beats start", {15'd0, req_valid}, 16'd0);
        check_regs("R10 kill+start");

        // R6 unusable code, then R7 start blocked by pending device error
        wr(8'h00, 8'hFE); m_sts = 8'h00;
        m_addr = 8'h50; wr(8'h04, m_addr);
        wr(8'h02, 8'h59); m_ctl = 8'h19; m_sts = 8'h04;
        chk("R6 i2c-block write rejected", {15'd0, req_valid}, 16'd0);
        wr(8'h02, 8'h45);
        m_ctl = 8'h05;
        chk("R7 blocked", {15'd0, req_valid}, 16'd0);
        check_regs("R7 deverr kept");
        // R9 error response
        wr(8'h00, 8'hFE); m_sts = 8'h00;
        m_addr = 8'h61; wr(8'h04, m_addr);
        wr(8'h02, 8'h45); m_ctl = 8'h05; m_sts[0] = 1'b1;
        @(negedge clk); #1;
        respond(1'b1, 16'hFFFF);
        model_result(3'd1, 1'b1, 1'b1, 16'hFFFF);
        check_regs("R9 error");

        // random mix
        for (int it = 0; it < 250; it++) begin
            logic [7:0] mask;
            if ($urandom_range(0, 2) != 0) begin
                mask = 8'($urandom);
                wr(8'h00, mask);
                m_sts = m_sts & ~(mask & 8'hFE);
            end
            do_txn(3'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom_range(0, 3) == 0), 16'($urandom),
                   $urandom_range(0, 3));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule